// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a simple request/response port on the CPU side to asynchronous SRAM-style memory. The external bus multiplexes the low address byte and the data byte on one 8-bit lane, which a latch strobe separates in time. The high address byte has its own port. The CPU side offers one request at a time. A request is taken only while the controller is idle, and completion is signalled by a one-clock done pulse. For reads, the captured byte comes back with that pulse.

Every access runs through the same sequence. First comes an address cycle with the latch strobe high, then a cycle with the latch strobe low. Next is a strobe phase, whose length comes from a 2-bit wait code. Code 11 adds one optional hold cycle, and a turnaround cycle ends the access. The address space is split at a programmable limit on the high address byte, and each side of the limit has its own wait code. When the controller is not driving the shared lane, an optional keeper holds the last driven byte. The lane itself is modelled as separate out, enable and in signals.

Top module: `xmb_ctrl`

## Requirements
- R1: After reset, ready is 1; the latch strobe, done and lane enable are 0; both strobes are high (1); the high address port is 0; the lane output is 0.
- R2: The cycle after a request is accepted is the address cycle. In it, the latch strobe is 1, the lane is driven with address bits [7:0], and the high port carries address bits [15:8]. In the next cycle the latch strobe is 0 and the high port still carries the high byte.
- R3: During the strobe phase, a read drives rd_n to 0 and a write drives wr_n to 0. Outside that phase both strobes are 1, and they are never low together.
- R4: The strobe phase lasts 1, 2, 3 and 3 cycles for wait codes 00, 01, 10 and 11.
- R5: With wait code 11, one extra cycle follows the strobe phase. In it both strobes are 1 and the high port still carries the high address. In the done and idle cycles the high port is 0.
- R6: The wait code is taken from cfg_wait_lo when request address bits [15:8] are strictly below cfg_limit, and from cfg_wait_hi otherwise. It is sampled when the request is accepted.
- R7: A write drives its data on the lane from the cycle after the address cycle through the last strobe cycle. A read leaves the lane undriven from that same cycle onward, and so does every cycle after the strobe phase.
- R8: Whenever the lane is not driven, ad_o holds the last byte driven on it. ad_keep is 1 exactly when cfg_keep_en is 1 and the lane is not driven.
- R9: A read captures ad_i in its last strobe cycle. The captured byte is shown on rsp_rdata from the done cycle onward and is held until the next read.
- R10: rsp_done is 1 for exactly one cycle, the cycle right after the strobe phase (or after the hold cycle). ready returns to 1 in the next cycle.
- R11: ready is 0 from the address cycle through the done cycle. Request inputs that change during an access have no effect on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_limit | input | 8 | Sector limit on address bits [15:8] |
| cfg_wait_lo | input | 2 | Wait code below the limit |
| cfg_wait_hi | input | 2 | Wait code at or above the limit |
| cfg_keep_en | input | 1 | Bus keeper enable |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, request accepted on this edge if valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read byte |
| ad_o | output | 8 | Shared address/data lane, output value |
| ad_oe | output | 1 | Lane driven by the controller |
| ad_keep | output | 1 | Keeper holding the lane |
| ad_i | input | 8 | Shared lane, input value |
| ah_o | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The request is accepted at the clock edge where valid and ready are both high. The address cycle then begins one cycle later, the latch-low cycle two cycles later, and the strobe phase three cycles later. The strobe phase lasts one more cycle than the extra count of the wait code. The hold cycle, if any, and then the done cycle follow it. Ready returns one cycle after done. Each scenario task drives its inputs on the falling edge and re-samples every output at the next falling edge, so each cycle of this timeline is checked in its own slot. The bench computes the expected wait code from its own copy of the sector limit and the request address. To show that a read captures data at the end of the strobe, the bench changes ad_i right after the strobe.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_LATCH, ST_STRB, ST_HOLD, ST_TURN
  } xmb_state_e;

  localparam int WCODE_W = 2;

  // extra strobe cycles per wait code
  function automatic logic [1:0] strobe_extra(input logic [WCODE_W-1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  // code 11 keeps the high address one cycle past the strobe
  function automatic logic post_hold(input logic [WCODE_W-1:0] code);
    return code == 2'b11;
  endfunction
endpackage

// File: rtl/xmb_sector_sel.sv
module xmb_sector_sel #(
  parameter int HI_W = 8
) (
  input  logic [HI_W-1:0]             addr_hi,
  input  logic [HI_W-1:0]             limit,
  input  logic [xmb_pkg::WCODE_W-1:0] wait_lo,
  input  logic [xmb_pkg::WCODE_W-1:0] wait_hi,
  output logic [xmb_pkg::WCODE_W-1:0] wcode
);
  assign wcode = (addr_hi < limit) ? wait_lo : wait_hi;
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WCODE_W-1:0] wcode,
  output xmb_state_e         st,
  output logic               strb_last
);
  logic [1:0] cnt;
  logic       hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      hold_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_ADDR;
          cnt    <= strobe_extra(wcode);
          hold_q <= post_hold(wcode);
        end
        ST_ADDR:  st <= ST_LATCH;
        ST_LATCH: st <= ST_STRB;
        ST_STRB: begin
          if (cnt == 2'd0) st <= hold_q ? ST_HOLD : ST_TURN;
          else             cnt <= cnt - 2'd1;
        end
        ST_HOLD:  st <= ST_TURN;
        ST_TURN:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign strb_last = (st == ST_STRB) && (cnt == 2'd0);
endmodule

// File: rtl/xmb_busdrv.sv
module xmb_busdrv
  import xmb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xmb_state_e        st,
  input  logic              wr,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              keep_en,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic              ad_keep
);
  logic [DATA_W-1:0] last_q;
  logic [DATA_W-1:0] drive;

  always_comb begin
    ad_oe = (st == ST_ADDR) || (wr && ((st == ST_LATCH) || (st == ST_STRB)));
    drive = (st == ST_ADDR) ? addr_lo : wdata;
    ad_o  = ad_oe ? drive : last_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        last_q <= '0;
    else if (ad_oe) last_q <= drive;
  end

  assign ad_keep = keep_en && !ad_oe;
endmodule

// File: rtl/xmb_ctrl.sv
module xmb_ctrl
  import xmb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HI_W-1:0]    cfg_limit,
  input  logic [WCODE_W-1:0] cfg_wait_lo,
  input  logic [WCODE_W-1:0] cfg_wait_hi,
  input  logic               cfg_keep_en,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [DATA_W-1:0]  ad_o,
  output logic               ad_oe,
  output logic               ad_keep,
  input  logic [DATA_W-1:0]  ad_i,
  output logic [HI_W-1:0]    ah_o,
  output logic               ale,
  output logic               rd_n,
  output logic               wr_n
);
  xmb_state_e        st;
  logic              strb_last;
  logic              start;
  logic [WCODE_W-1:0] wcode;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;
  logic [DATA_W-1:0] rdata_q;

  assign req_ready = (st == ST_IDLE);
  assign start     = req_valid && req_ready;

  xmb_sector_sel #(.HI_W(HI_W)) u_sector (
    .addr_hi (req_addr[ADDR_W-1:DATA_W]),
    .limit   (cfg_limit),
    .wait_lo (cfg_wait_lo),
    .wait_hi (cfg_wait_hi),
    .wcode   (wcode)
  );

  xmb_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wcode     (wcode),
    .st        (st),
    .strb_last (strb_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
      end
      if (strb_last && !wr_q) rdata_q <= ad_i;
    end
  end

  xmb_busdrv #(.DATA_W(DATA_W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .st      (st),
    .wr      (wr_q),
    .addr_lo (addr_q[DATA_W-1:0]),
    .wdata   (wdata_q),
    .keep_en (cfg_keep_en),
    .ad_o    (ad_o),
    .ad_oe   (ad_oe),
    .ad_keep (ad_keep)
  );

  always_comb begin
    ale       = (st == ST_ADDR);
    rd_n      = !((st == ST_STRB) && !wr_q);
    wr_n      = !((st == ST_STRB) && wr_q);
    rsp_done  = (st == ST_TURN);
    rsp_rdata = rdata_q;
    case (st)
      ST_ADDR, ST_LATCH, ST_STRB, ST_HOLD: ah_o = addr_q[ADDR_W-1:DATA_W];
      default:                              ah_o = '0;
    endcase
  end
endmodule

// File: rtl/xmb_ctrl_chk.sv
module xmb_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R3
  AST_ALE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R2
  AST_ALE_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && ad_oe)); // R2
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe); // R7
  AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ad_oe |=> (ad_oe || $stable(ad_o))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> (!rsp_done && req_ready)); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && ale)); // R11
endmodule

bind xmb_ctrl xmb_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_xmb_ctrl.sv
module tb_xmb_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_limit = 8'h80;
  logic [1:0]  cfg_wait_lo = 2'b00;
  logic [1:0]  cfg_wait_hi = 2'b00;
  logic        cfg_keep_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, ad_oe, ad_keep, ale, rd_n, wr_n;
  logic [7:0]  rsp_rdata, ad_o, ah_o;
  logic [7:0]  ad_i = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xmb_ctrl dut (
    .clk(clk), .rst(rst), .cfg_limit(cfg_limit), .cfg_wait_lo(cfg_wait_lo),
    .cfg_wait_hi(cfg_wait_hi), .cfg_keep_en(cfg_keep_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_keep(ad_keep), .ad_i(ad_i), .ah_o(ah_o),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // one access; expected wait code derived from the bench's own sector rule
  task automatic do_access(input bit wr, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] rdv);
    logic [1:0] code;
    int ext;
    bit hold;
    code = (addr[15:8] < cfg_limit) ? cfg_wait_lo : cfg_wait_hi; // R6
    ext  = (code == 2'b00) ? 0 : (code == 2'b01) ? 1 : 2;        // R4
    hold = (code == 2'b11);                                        // R5
    @(negedge clk);
    chk("R11", "ready idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    ad_i = ~rdv;
    @(negedge clk); // address cycle
    chk("R2", "ale", ale, 1);
    chk("R2", "lane oe", ad_oe, 1);
    chk("R2", "lane low addr", ad_o, addr[7:0]);
    chk("R2", "high addr", ah_o, addr[15:8]);
    chk("R3", "strobes idle", {rd_n, wr_n}, 2'b11);
    chk("R11", "ready busy", req_ready, 0);
    req_addr = ~addr; req_wdata = ~wd; req_write = !wr; // held off, keep valid
    @(negedge clk); // latch low
    chk("R2", "ale low", ale, 0);
    chk("R2", "high addr latch", ah_o, addr[15:8]);
    chk("R7", "lane oe latch", ad_oe, wr);
    if (wr) chk("R7", "write data latch", ad_o, wd);
    chk("R3", "strobes latch", {rd_n, wr_n}, 2'b11);
    chk("R11", "ready busy latch", req_ready, 0);
    if (!wr) ad_i = rdv;
    for (int i = 0; i <= ext; i++) begin
      @(negedge clk);
      chk("R4", "strobe active", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
      chk("R7", "lane oe strobe", ad_oe, wr);
      if (wr) chk("R7", "write data strobe", ad_o, wd);
      else begin
        chk("R8", "keep flag strobe", ad_keep, cfg_keep_en);
        chk("R8", "kept byte strobe", ad_o, addr[7:0]);
      end
      chk("R11", "bus ignores new req", ah_o, addr[15:8]);
    end
    @(negedge clk);
    ad_i = rdv ^ 8'hFF;
    if (hold) begin
      chk("R5", "hold strobes high", {rd_n, wr_n}, 2'b11);
      chk("R5", "hold high addr", ah_o, addr[15:8]);
      chk("R7", "hold lane free", ad_oe, 0);
      chk("R10", "no done in hold", rsp_done, 0);
      @(negedge clk);
    end
    chk("R10", "done pulse", rsp_done, 1);
    chk("R4", "strobe ended", {rd_n, wr_n}, 2'b11);
    chk("R5", "high addr cleared", ah_o, 0);
    chk("R11", "ready in done", req_ready, 0);
    if (!wr) chk("R9", "read data", rsp_rdata, rdv);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "done dropped", rsp_done, 0);
    chk("R10", "ready back", req_ready, 1);
    chk("R7", "lane free idle", ad_oe, 0);
    chk("R8", "keep flag idle", ad_keep, cfg_keep_en);
    chk("R8", "kept byte idle", ad_o, wr ? wd : addr[7:0]);
    if (!wr) chk("R9", "read data held", rsp_rdata, rdv);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ready", req_ready, 1);
    chk("R1", "ale/done/oe", {ale, rsp_done, ad_oe}, 3'b000);
    chk("R1", "strobes", {rd_n, wr_n}, 2'b11);
    chk("R1", "high addr", ah_o, 0);
    chk("R1", "lane out", ad_o, 0);
    chk("R8", "keep at reset", ad_keep, 1);
  endtask

  task automatic t_write_fast();   // sector 0, code 00
    cfg_wait_lo = 2'b00; cfg_wait_hi = 2'b10; cfg_keep_en = 1'b1;
    do_access(1'b1, 16'h1234, 8'hA5, 8'h00);
  endtask

  task automatic t_read_one_wait(); // sector 1, code 01
    cfg_wait_lo = 2'b11; cfg_wait_hi = 2'b01;
    do_access(1'b0, 16'h9A55, 8'h00, 8'h3C);
  endtask

  task automatic t_read_two_wait_nokeep(); // just below limit, code 10
    cfg_wait_lo = 2'b10; cfg_wait_hi = 2'b00; cfg_keep_en = 1'b0;
    do_access(1'b0, 16'h7F01, 8'h00, 8'hC3);
  endtask

  task automatic t_write_hold_boundary(); // at limit -> sector 1, code 11
    cfg_wait_lo = 2'b00; cfg_wait_hi = 2'b11; cfg_keep_en = 1'b1;
    do_access(1'b1, 16'h8000, 8'h96, 8'h00);
  endtask

  task automatic t_read_hold(); // top of space, code 11
    do_access(1'b0, 16'hFFFE, 8'h00, 8'h5E);
  endtask

  task automatic t_write_nokeep_low(); // bottom of space, keeper off
    cfg_wait_lo = 2'b01; cfg_keep_en = 1'b0;
    do_access(1'b1, 16'h0003, 8'h71, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_fast();
    t_read_one_wait();
    t_read_two_wait_nokeep();
    t_write_hold_boundary();
    t_read_hold();
    t_write_nokeep_low();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule